// File: doc/BRIEF.md
# CPU Bus Address Router

This block sits between a 32-bit CPU load/store port and four targets: a boot ROM window, a 128-bit-wide RAM, the register window of a DMA channel and the register window of an interrupt controller. It turns each virtual address into a physical one by clearing the top three bits. It then decodes the physical address and drives exactly one target. Each target answers a read one cycle later, and the router returns the answer to the CPU on a one-cycle valid pulse.

The RAM is shared with two other masters: a DMA engine that reads whole 128-bit rows, and a bridge that writes whole rows under a byte mask. The CPU always wins a collision on the RAM. A master that loses sees its grant low for that cycle and keeps its request steady until a later cycle. A CPU read from a physical address that no target claims returns a fixed poison word, so a stray pointer is easy to spot. A CPU write to such an address is dropped.

Top module: `cpu_bus_router`

## Requirements
- R1: Out of reset, with no requests, `cpu_rvalid` and `dma_rd_valid` are low.
- R2: Virtual address bits [31:29] are ignored. For example, 0x8000_0050 and 0xA000_0050 reach the same RAM word.
- R3: A CPU read of RAM physical address p (p < RAM_BYTES) returns the 32-bit lane p[3:2] of RAM row p[4 +: ROW_W]. Lane k is bits [32k+31:32k] of the row. The data arrives with `cpu_rvalid` high in the cycle after the request, and `cpu_rvalid` is high in no other cycle.
- R4: A CPU write to RAM puts the word into every lane of `ram_wr_data` and sets the RAM mask to `cpu_be` shifted left by 4*p[3:2]. Bytes outside that mask, including the other three lanes, keep their old values.
- R5: If a CPU RAM read and a DMA row read fall in the same cycle, the CPU read is served and `dma_rd_gnt` is low. A granted DMA read returns the full row on `dma_rd_valid` one cycle later.
- R6: If a CPU RAM write and a bridge row write fall in the same cycle, the CPU write is applied and `br_wr_gnt` is low. A granted bridge write uses its own row, data and mask.
- R7: Physical bits [28:12] equal to 0x1000A select the DMA register window. Writes go out on `dreg_wr_en` and reads on `dreg_rd_en`, both with offset p[11:0], and the read data comes back to the CPU.
- R8: Physical bits [28:12] equal to 0x1000F select the interrupt controller window, which holds status at offset 0x000 and mask at offset 0x010. Writes and reads are forwarded with offset p[11:0].
- R9: The ROM window starts at physical ROM_BASE (0x1FC0_0000, which holds the reset vector 0xBFC0_0000) and is ROM_BYTES long. Reads present word address (p - ROM_BASE)[.. :2]. Writes to the ROM window reach no target.
- R10: A CPU read of an unmapped address returns 0xDEADBEEF with `cpu_rvalid` one cycle later. A CPU write to an unmapped address raises no target write enable.
- R11: A CPU access to a target other than RAM does not block the DMA read port or the bridge write port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | CPU access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | CPU virtual address |
| cpu_wdata | input | 32 | CPU write data |
| cpu_be | input | 4 | CPU byte enables within the word |
| cpu_rvalid | output | 1 | Read data valid pulse |
| cpu_rdata | output | 32 | Read data |
| dma_rd_req | input | 1 | DMA row read request |
| dma_rd_row | input | ROW_W | DMA row index |
| dma_rd_gnt | output | 1 | DMA read accepted this cycle |
| dma_rd_valid | output | 1 | DMA read data valid |
| dma_rd_data | output | 128 | DMA read row |
| br_wr_req | input | 1 | Bridge row write request |
| br_wr_row | input | ROW_W | Bridge row index |
| br_wr_data | input | 128 | Bridge write row |
| br_wr_mask | input | 16 | Bridge byte mask |
| br_wr_gnt | output | 1 | Bridge write accepted this cycle |
| ram_rd_en | output | 1 | RAM read enable |
| ram_rd_row | output | ROW_W | RAM read row |
| ram_rd_data | input | 128 | RAM read data, one cycle after enable |
| ram_wr_en | output | 1 | RAM write enable |
| ram_wr_row | output | ROW_W | RAM write row |
| ram_wr_data | output | 128 | RAM write data |
| ram_wr_mask | output | 16 | RAM byte mask |
| rom_rd_en | output | 1 | ROM read enable |
| rom_addr | output | ROM_AW | ROM word address |
| rom_rd_data | input | 32 | ROM data, one cycle after enable |
| dreg_wr_en | output | 1 | DMA register write |
| dreg_rd_en | output | 1 | DMA register read |
| dreg_off | output | 12 | DMA register byte offset |
| dreg_wdata | output | 32 | DMA register write data |
| dreg_rdata | input | 32 | DMA register read data |
| ic_wr_en | output | 1 | Interrupt controller register write |
| ic_rd_en | output | 1 | Interrupt controller register read |
| ic_off | output | 12 | Interrupt controller byte offset |
| ic_wdata | output | 32 | Interrupt controller write data |
| ic_rdata | input | 32 | Interrupt controller read data |

## Verification
RAM reads are run over all four lanes of one row, with every lane holding a distinct value, so that a wrong lane index shows as a wrong word. The same word is read through two virtual aliases. A partial-byte write into an inner lane, followed by reads of the whole row, separates a correct shifted mask from a write that spills into the lanes around it. The collision tests give the CPU and the other master a request in the same cycle and then repeat the other master's request alone. They check that the grant stays low only while the CPU is using the RAM, and that the held write lands afterwards. Register-window, ROM and unmapped accesses are checked both for the data they return and, through write counters in the target models, for having touched no target on a dropped write.

// File: rtl/cpu_bus_router.sv
module cpu_bus_router #(
  parameter int          RAM_BYTES = 4096,
  parameter int          ROM_BYTES = 4096,
  parameter logic [31:0] ROM_BASE  = 32'h1FC0_0000,
  parameter logic [31:0] POISON    = 32'hDEAD_BEEF,
  localparam int         ROW_W     = $clog2(RAM_BYTES / 16),
  localparam int         ROM_AW    = $clog2(ROM_BYTES / 4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [31:0]       cpu_addr,
  input  logic [31:0]       cpu_wdata,
  input  logic [3:0]        cpu_be,
  output logic              cpu_rvalid,
  output logic [31:0]       cpu_rdata,
  input  logic              dma_rd_req,
  input  logic [ROW_W-1:0]  dma_rd_row,
  output logic              dma_rd_gnt,
  output logic              dma_rd_valid,
  output logic [127:0]      dma_rd_data,
  input  logic              br_wr_req,
  input  logic [ROW_W-1:0]  br_wr_row,
  input  logic [127:0]      br_wr_data,
  input  logic [15:0]       br_wr_mask,
  output logic              br_wr_gnt,
  output logic              ram_rd_en,
  output logic [ROW_W-1:0]  ram_rd_row,
  input  logic [127:0]      ram_rd_data,
  output logic              ram_wr_en,
  output logic [ROW_W-1:0]  ram_wr_row,
  output logic [127:0]      ram_wr_data,
  output logic [15:0]       ram_wr_mask,
  output logic              rom_rd_en,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [31:0]       rom_rd_data,
  output logic              dreg_wr_en,
  output logic              dreg_rd_en,
  output logic [11:0]       dreg_off,
  output logic [31:0]       dreg_wdata,
  input  logic [31:0]       dreg_rdata,
  output logic              ic_wr_en,
  output logic              ic_rd_en,
  output logic [11:0]       ic_off,
  output logic [31:0]       ic_wdata,
  input  logic [31:0]       ic_rdata
);

  typedef enum logic [2:0] {SRC_NONE, SRC_RAM, SRC_ROM, SRC_DREG, SRC_IC, SRC_POISON} src_e;

  logic [31:0] phys, rom_off;
  logic        hit_ram, hit_rom, hit_dreg, hit_ic;
  logic        cpu_rd, cpu_wr, cpu_ram_rd, cpu_ram_wr;
  logic [1:0]  lane, lane_q;
  src_e        src_d, src_q;
  logic        dma_q;

  assign phys     = {3'b000, cpu_addr[28:0]};
  assign rom_off  = phys - ROM_BASE;
  assign hit_ram  = phys < 32'(RAM_BYTES);
  assign hit_rom  = (phys >= ROM_BASE) && (rom_off < 32'(ROM_BYTES));
  assign hit_dreg = phys[28:12] == 17'h1000A;
  assign hit_ic   = phys[28:12] == 17'h1000F;
  assign lane     = phys[3:2];

  assign cpu_rd     = cpu_req & ~cpu_we;
  assign cpu_wr     = cpu_req &  cpu_we;
  assign cpu_ram_rd = cpu_rd & hit_ram;
  assign cpu_ram_wr = cpu_wr & hit_ram;

  assign dma_rd_gnt = dma_rd_req & ~cpu_ram_rd;
  assign ram_rd_en  = cpu_ram_rd | dma_rd_req;
  assign ram_rd_row = cpu_ram_rd ? phys[4 +: ROW_W] : dma_rd_row;

  assign br_wr_gnt   = br_wr_req & ~cpu_ram_wr;
  assign ram_wr_en   = cpu_ram_wr | br_wr_req;
  assign ram_wr_row  = cpu_ram_wr ? phys[4 +: ROW_W] : br_wr_row;
  assign ram_wr_data = cpu_ram_wr ? {4{cpu_wdata}} : br_wr_data;
  assign ram_wr_mask = cpu_ram_wr ? (16'(cpu_be) << {lane, 2'b00}) : br_wr_mask;

  assign rom_rd_en  = cpu_rd & hit_rom;
  assign rom_addr   = rom_off[2 +: ROM_AW];

  assign dreg_wr_en = cpu_wr & hit_dreg;
  assign dreg_rd_en = cpu_rd & hit_dreg;
  assign dreg_off   = phys[11:0];
  assign dreg_wdata = cpu_wdata;

  assign ic_wr_en   = cpu_wr & hit_ic;
  assign ic_rd_en   = cpu_rd & hit_ic;
  assign ic_off     = phys[11:0];
  assign ic_wdata   = cpu_wdata;

  always_comb begin
    src_d = SRC_NONE;
    if (cpu_rd) begin
      if      (hit_ram)  src_d = SRC_RAM;
      else if (hit_rom)  src_d = SRC_ROM;
      else if (hit_dreg) src_d = SRC_DREG;
      else if (hit_ic)   src_d = SRC_IC;
      else               src_d = SRC_POISON;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= SRC_NONE;
      lane_q <= 2'd0;
      dma_q  <= 1'b0;
    end else begin
      src_q  <= src_d;
      lane_q <= lane;
      dma_q  <= dma_rd_gnt;
    end
  end

  assign cpu_rvalid   = src_q != SRC_NONE;
  assign dma_rd_valid = dma_q;
  assign dma_rd_data  = ram_rd_data;

  always_comb begin
    case (src_q)
      SRC_RAM:  cpu_rdata = ram_rd_data[32*lane_q +: 32];
      SRC_ROM:  cpu_rdata = rom_rd_data;
      SRC_DREG: cpu_rdata = dreg_rdata;
      SRC_IC:   cpu_rdata = ic_rdata;
      SRC_POISON: cpu_rdata = POISON;
      default:  cpu_rdata = 32'd0;
    endcase
  end

endmodule

// File: rtl/cpu_bus_router_chk.sv
module cpu_bus_router_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_req,
  input logic        cpu_we,
  input logic        cpu_rvalid,
  input logic        dma_rd_req,
  input logic        dma_rd_gnt,
  input logic        dma_rd_valid,
  input logic        br_wr_req,
  input logic        br_wr_gnt,
  input logic [15:0] br_wr_mask,
  input logic        ram_rd_en,
  input logic        ram_wr_en,
  input logic [15:0] ram_wr_mask,
  input logic        rom_rd_en,
  input logic        dreg_rd_en,
  input logic        dreg_wr_en,
  input logic        ic_rd_en,
  input logic        ic_wr_en
);

  AST_DMA_GNT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rd_gnt |-> (dma_rd_req && ram_rd_en)); // R5
  AST_DMA_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rd_gnt |=> dma_rd_valid); // R5
  AST_DMA_VALID_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_rd_gnt |=> !dma_rd_valid); // R5
  AST_BR_GNT_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    br_wr_gnt |-> (ram_wr_en && ram_wr_mask == br_wr_mask)); // R6
  AST_BR_ONLY_LOSES_TO_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    (br_wr_req && !br_wr_gnt) |-> (cpu_req && cpu_we && ram_wr_en)); // R6
  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_we) |=> cpu_rvalid); // R3
  AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_req && !cpu_we) |=> !cpu_rvalid); // R10
  AST_CPU_LANE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_wr_en && !br_wr_gnt) |-> ($countones(ram_wr_mask) <= 4)); // R4
  AST_ONE_READ_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_rd_en, dreg_rd_en, ic_rd_en})); // R9
  AST_ONE_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dreg_wr_en, ic_wr_en})); // R7

endmodule

bind cpu_bus_router cpu_bus_router_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_rvalid(cpu_rvalid),
  .dma_rd_req(dma_rd_req), .dma_rd_gnt(dma_rd_gnt), .dma_rd_valid(dma_rd_valid),
  .br_wr_req(br_wr_req), .br_wr_gnt(br_wr_gnt), .br_wr_mask(br_wr_mask),
  .ram_rd_en(ram_rd_en), .ram_wr_en(ram_wr_en), .ram_wr_mask(ram_wr_mask),
  .rom_rd_en(rom_rd_en), .dreg_rd_en(dreg_rd_en), .dreg_wr_en(dreg_wr_en),
  .ic_rd_en(ic_rd_en), .ic_wr_en(ic_wr_en)
);

// File: tb/cpu_bus_router_test.sv
`timescale 1ns/1ps
module cpu_bus_router_test;
  localparam int ROW_W = 8;
  localparam int ROM_AW = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic cpu_req = 0, cpu_we = 0;
  logic [31:0] cpu_addr = 0, cpu_wdata = 0;
  logic [3:0] cpu_be = 0;
  logic cpu_rvalid;
  logic [31:0] cpu_rdata;
  logic dma_rd_req = 0;
  logic [ROW_W-1:0] dma_rd_row = 0;
  logic dma_rd_gnt, dma_rd_valid;
  logic [127:0] dma_rd_data;
  logic br_wr_req = 0;
  logic [ROW_W-1:0] br_wr_row = 0;
  logic [127:0] br_wr_data = 0;
  logic [15:0] br_wr_mask = 0;
  logic br_wr_gnt;
  logic ram_rd_en, ram_wr_en;
  logic [ROW_W-1:0] ram_rd_row, ram_wr_row;
  logic [127:0] ram_rd_data, ram_wr_data;
  logic [15:0] ram_wr_mask;
  logic rom_rd_en;
  logic [ROM_AW-1:0] rom_addr;
  logic [31:0] rom_rd_data;
  logic dreg_wr_en, dreg_rd_en, ic_wr_en, ic_rd_en;
  logic [11:0] dreg_off, ic_off;
  logic [31:0] dreg_wdata, dreg_rdata, ic_wdata, ic_rdata;

  cpu_bus_router uut (.*);

  // target models
  logic [127:0] mem [256];
  logic [31:0] dregs [16];
  logic [31:0] ic_stat, ic_mask;
  int tgt_writes = 0;

  function automatic logic [127:0] seed_row(int r);
    for (int k = 0; k < 4; k++) seed_row[32*k +: 32] = {8'(r), 8'(k), 16'hA5C3};
  endfunction

  initial begin
    for (int r = 0; r < 256; r++) mem[r] = seed_row(r);
    for (int i = 0; i < 16; i++) dregs[i] = 0;
    ic_stat = 0; ic_mask = 0;
  end

  always @(posedge clk) begin
    if (ram_rd_en) ram_rd_data <= mem[ram_rd_row];
    if (ram_wr_en) begin
      tgt_writes <= tgt_writes + 1;
      for (int b = 0; b < 16; b++)
        if (ram_wr_mask[b]) mem[ram_wr_row][8*b +: 8] <= ram_wr_data[8*b +: 8];
    end
    if (rom_rd_en) rom_rd_data <= 32'hB0C0_0000 | 32'(rom_addr);
    if (dreg_rd_en) dreg_rdata <= dregs[dreg_off[5:2]];
    if (dreg_wr_en) begin dregs[dreg_off[5:2]] <= dreg_wdata; tgt_writes <= tgt_writes + 1; end
    if (ic_rd_en) ic_rdata <= (ic_off == 12'h010) ? ic_mask : (ic_off == 12'h000) ? ic_stat : 32'h0;
    if (ic_wr_en) begin
      tgt_writes <= tgt_writes + 1;
      if (ic_off == 12'h000) ic_stat <= ic_wdata;
      if (ic_off == 12'h010) ic_mask <= ic_wdata;
    end
  end

  int n_chk = 0, n_bad = 0;

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d, output logic v);
    cpu_req = 1; cpu_we = 0; cpu_addr = a;
    @(negedge clk);
    v = cpu_rvalid; d = cpu_rdata; cpu_req = 0;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
    cpu_req = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d; cpu_be = be;
    @(negedge clk);
    cpu_req = 0; cpu_we = 0;
  endtask

  task automatic t_reset;
    chk("R1 cpu_rvalid", cpu_rvalid, 0);
    chk("R1 dma_rd_valid", dma_rd_valid, 0);
  endtask

  task automatic t_lanes;
    logic [31:0] d; logic v;
    for (int k = 0; k < 4; k++) begin
      rd(32'h8000_0050 + 32'(4*k), d, v);
      chk("R3 valid", v, 1);
      chk("R3 lane data", d, {8'd5, 8'(k), 16'hA5C3});
      @(negedge clk);
      chk("R3 one pulse", cpu_rvalid, 0);
    end
    rd(32'hA000_0058, d, v);
    chk("R2 alias", d, {8'd5, 8'd2, 16'hA5C3});
  endtask

  task automatic t_write;
    logic [31:0] d; logic v;
    wr(32'h8000_0078, 32'h1122_3344, 4'b0101);
    for (int k = 0; k < 4; k++) begin
      rd(32'h0000_0070 + 32'(4*k), d, v);
      if (k == 2) chk("R4 merged lane", d, {8'd7, 8'h22, 8'hA5, 8'h44});
      else        chk("R4 other lane kept", d, {8'd7, 8'(k), 16'hA5C3});
    end
  endtask

  task automatic t_dma_collide;
    cpu_req = 1; cpu_we = 0; cpu_addr = 32'h0000_0084;
    dma_rd_req = 1; dma_rd_row = 8'd9;
    #1 chk("R5 dma loses", dma_rd_gnt, 0);
    @(negedge clk);
    chk("R5 cpu served", cpu_rdata, {8'd8, 8'd1, 16'hA5C3});
    chk("R5 no dma valid", dma_rd_valid, 0);
    cpu_req = 0;
    #1 chk("R5 dma granted", dma_rd_gnt, 1);
    @(negedge clk);
    dma_rd_req = 0;
    chk("R5 dma valid", dma_rd_valid, 1);
    chk("R5 dma row", dma_rd_data, seed_row(9));
  endtask

  task automatic t_br_collide;
    logic [31:0] d; logic v;
    cpu_req = 1; cpu_we = 1; cpu_addr = 32'h0000_00A0; cpu_wdata = 32'hCAFE_0001; cpu_be = 4'hF;
    br_wr_req = 1; br_wr_row = 8'd10; br_wr_data = {4{32'hBEEF_0002}}; br_wr_mask = 16'hF000;
    #1 chk("R6 bridge loses", br_wr_gnt, 0);
    @(negedge clk);
    cpu_req = 0; cpu_we = 0;
    #1 chk("R6 bridge granted", br_wr_gnt, 1);
    @(negedge clk);
    br_wr_req = 0;
    rd(32'h0000_00A0, d, v);
    chk("R6 cpu write kept", d, 32'hCAFE_0001);
    rd(32'h0000_00AC, d, v);
    chk("R6 bridge write landed", d, 32'hBEEF_0002);
    rd(32'h0000_00A4, d, v);
    chk("R6 bridge mask honoured", d, {8'd10, 8'd1, 16'hA5C3});
  endtask

  task automatic t_dreg;
    logic [31:0] d; logic v;
    wr(32'hB000_A010, 32'h0000_1234, 4'hF);
    chk("R7 dreg written", dregs[4], 32'h0000_1234);
    rd(32'hB000_A010, d, v);
    chk("R7 dreg read", d, 32'h0000_1234);
  endtask

  task automatic t_intc;
    logic [31:0] d; logic v;
    wr(32'hB000_F000, 32'h0000_0004, 4'hF);
    wr(32'hB000_F010, 32'h0000_0404, 4'hF);
    rd(32'h1000_F000, d, v);
    chk("R8 status", d, 32'h0000_0004);
    rd(32'h1000_F010, d, v);
    chk("R8 mask", d, 32'h0000_0404);
  endtask

  task automatic t_rom;
    logic [31:0] d; logic v; int w0;
    rd(32'hBFC0_0000, d, v);
    chk("R9 reset vector", d, 32'hB0C0_0000);
    rd(32'hBFC0_0024, d, v);
    chk("R9 rom word", d, 32'hB0C0_0009);
    w0 = tgt_writes;
    wr(32'hBFC0_0000, 32'h1, 4'hF);
    @(negedge clk);
    chk("R9 rom write dropped", tgt_writes, w0);
  endtask

  task automatic t_unmapped;
    logic [31:0] d; logic v; int w0;
    rd(32'h1200_0000, d, v);
    chk("R10 poison valid", v, 1);
    chk("R10 poison", d, 32'hDEAD_BEEF);
    w0 = tgt_writes;
    wr(32'h1200_0000, 32'h5, 4'hF);
    @(negedge clk);
    chk("R10 write dropped", tgt_writes, w0);
  endtask

  task automatic t_side_ports;
    cpu_req = 1; cpu_we = 0; cpu_addr = 32'hBFC0_0000;
    dma_rd_req = 1; dma_rd_row = 8'd3;
    #1 chk("R11 dma not blocked", dma_rd_gnt, 1);
    @(negedge clk);
    cpu_req = 0; dma_rd_req = 0;
    chk("R11 dma row", dma_rd_data, seed_row(3));
    cpu_req = 1; cpu_we = 1; cpu_addr = 32'h1000_A000;
    br_wr_req = 1; br_wr_row = 8'd20; br_wr_mask = 16'h0;
    #1 chk("R11 bridge not blocked", br_wr_gnt, 1);
    @(negedge clk);
    cpu_req = 0; cpu_we = 0; br_wr_req = 0;
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog R1 actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_lanes();
    t_write();
    t_dma_collide();
    t_br_collide();
    t_dreg();
    t_intc();
    t_rom();
    t_unmapped();
    t_side_ports();
    @(negedge clk);
    finish_run();
  end
endmodule